// File: doc/BRIEF.md
# Raster Frame Timing Generator

This block produces the raster timebase for a tile-based video unit. A dot counter advances once per dot clock and wraps at the end of each scanline. A line counter advances at each wrap and closes the frame after a fixed number of lines. The frame runs continuously and software has no way to stop or pause it. Each frame passes through four line groups in a fixed order: one idle line, a run of vertical-blank lines, one prerender line and a run of render lines.

The generator also keeps a small amount of register state that the rest of the video unit and the processor depend on:

- a control enable bit that gates the vertical-blank interrupt;
- a background enable bit and a sprite enable bit;
- a vertical-blank flag that software reads through a status port, where the read clears the flag.

From the counters and these bits it derives a "rendering active" qualifier and a visible-pixel strobe for the pixel pipeline. It also derives a divide-by-three clock enable for the processor.

With default parameters a line is 341 dots and a frame is 262 lines, which gives 89342 dots per frame. Lines are numbered from the first render line:

| Lines | Group |
|-------|-------|
| 0 to 239 | render |
| 240 | idle |
| 241 to 260 | vertical blank |
| 261 | prerender |

Top module: `raster_timing_gen`

## Requirements
- R1: `dotCount` counts 0 to DOTS-1, one step per clock, and returns to 0 after DOTS-1.
- R2: `lineCount` advances by one when the dot counter wraps. The line after the prerender line (RENDER+IDLE+VBL, the last line) is line 0. Lines 0 to RENDER-1 are render lines, followed by IDLE idle lines and then VBL vertical-blank lines.
- R3: The vertical-blank flag is set by the clock edge that ends dot 1 of the first vertical-blank line (line RENDER+IDLE). It reads as bit 7 of `statusData`, and all other status bits are 0.
- R4: A cycle with `statusRd` high clears the flag at the end of that cycle. The read itself returns the flag value as it was before the clear.
- R5: The flag clears by itself at the edge that ends dot 1 of the prerender line.
- R6: When the flag sets and control bit 7 is 1, `irq` is high for exactly one dot, in the same cycle the flag first reads 1. When control bit 7 is 0, `irq` stays low.
- R7: A control write that changes bit 7 from 0 to 1 while the flag is set produces one further single-dot `irq` pulse in the next cycle. Writing bit 7 while the flag is clear produces no pulse.
- R8: `renderActive` is 1 only on render lines and the prerender line, and only when mask bit 3 (background) or mask bit 4 (sprites) is 1. The other mask bits have no effect on it.
- R9: `pixelValid` is 1 on render lines at dots 1 to VIS and 0 everywhere else, whatever the mask bits are.
- R10: `cpuClkEn` pulses once every DIV dots. It is first high on the third cycle after reset release (cycle index 2 for DIV=3).
- R11: Reset puts the generator at dot 0 of the first idle line (line RENDER). Reset also clears the flag, `irq` and all enable bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWrEn | input | 1 | Write strobe for the control register (bit 7 enables the interrupt) |
| maskWrEn | input | 1 | Write strobe for the mask register (bit 3 enables background, bit 4 enables sprites) |
| wrData | input | 8 | Write data for both registers |
| statusRd | input | 1 | Status read strobe; clears the vertical-blank flag |
| statusData | output | 8 | Status value; bit 7 is the vertical-blank flag |
| irq | output | 1 | Single-dot interrupt request |
| renderActive | output | 1 | High on the prerender and render lines while the display is on |
| pixelValid | output | 1 | High on visible dots of render lines |
| cpuClkEn | output | 1 | Processor clock enable, once every DIV dots |
| dotCount | output | DOT_W | Current dot in the line |
| lineCount | output | LINE_W | Current line in the frame |

## Verification
The bench builds the generator with a shrunk frame:

| Parameter | Value |
|-----------|-------|
| DOTS | 12 |
| VIS | 8 |
| RENDER | 4 |
| IDLE | 1 |
| VBL | 3 |
| DIV | 3 |

This gives 108 dots per frame. Several whole frames, every line-group boundary and the frame wrap are therefore reached within a few hundred cycles. The flag's set and clear edges, the interrupt from a late enable write, and read-clear timing are all placed at exact dot positions. The bench computes those positions from its own count of cycles since reset.

// File: rtl/raster_pkg.sv
package raster_pkg;

  // Strobes decoded from the counters, handed from control to datapath
  typedef struct packed {
    logic vblankSet;   // dot 1 of the first vertical-blank line
    logic vblankClr;   // dot 1 of the prerender line
    logic drawLine;    // render line or prerender line
    logic pixelSlot;   // visible dot of a render line
    logic cpuTick;     // processor clock enable
  } rasterStrobeT;

endpackage

// File: rtl/raster_ctrl.sv
module raster_ctrl
  import raster_pkg::*;
#(
  parameter int DOTS   = 341,
  parameter int VIS    = 256,
  parameter int RENDER = 240,
  parameter int IDLE   = 1,
  parameter int VBL    = 20,
  parameter int DIV    = 3,
  localparam int TOTAL  = RENDER + IDLE + VBL + 1,
  localparam int DOT_W  = $clog2(DOTS),
  localparam int LINE_W = $clog2(TOTAL)
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [DOT_W-1:0]  dotCount,
  output logic [LINE_W-1:0] lineCount,
  output rasterStrobeT      strobes
);

  localparam int VBL_FIRST = RENDER + IDLE;
  localparam int PRE_LINE  = TOTAL - 1;
  localparam int DIV_W     = $clog2(DIV + 1);

  logic [DIV_W-1:0] divCount;
  logic             lineEnd;

  assign lineEnd = (dotCount == DOT_W'(DOTS - 1));

  // Free-running dot, line and processor-divider counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dotCount  <= '0;
      lineCount <= LINE_W'(RENDER);
      divCount  <= '0;
    end else begin
      dotCount <= lineEnd ? '0 : dotCount + 1'b1;
      if (lineEnd)
        lineCount <= (lineCount == LINE_W'(PRE_LINE)) ? '0 : lineCount + 1'b1;
      divCount <= (divCount == DIV_W'(DIV - 1)) ? '0 : divCount + 1'b1;
    end
  end

  // Decode counters into strobes
  always_comb begin
    strobes.vblankSet = (lineCount == LINE_W'(VBL_FIRST)) && (dotCount == DOT_W'(1));
    strobes.vblankClr = (lineCount == LINE_W'(PRE_LINE))  && (dotCount == DOT_W'(1));
    strobes.drawLine  = (lineCount < LINE_W'(RENDER)) || (lineCount == LINE_W'(PRE_LINE));
    strobes.pixelSlot = (lineCount < LINE_W'(RENDER)) && (dotCount != '0)
                        && (dotCount <= DOT_W'(VIS));
    strobes.cpuTick   = (divCount == DIV_W'(DIV - 1));
  end

  // R1: dot counter returns to zero after the last dot
  p_dot_wrap_r1: assert property (@(posedge clk) disable iff (!rstN)
    (dotCount == DOT_W'(DOTS - 1)) |=> (dotCount == '0));

  // R2: line counter steps once per line
  p_line_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (lineEnd && lineCount != LINE_W'(PRE_LINE)) |=> (lineCount == $past(lineCount) + 1'b1));

  // R2: line after the prerender line is line 0
  p_line_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (lineEnd && lineCount == LINE_W'(PRE_LINE)) |=> (lineCount == '0));

  // R2: line holds within a scanline
  p_line_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !lineEnd |=> $stable(lineCount));

  // R10: no two consecutive processor enables
  generate
    if (DIV > 1) begin : g_divChk
      p_cpu_gap_r10: assert property (@(posedge clk) disable iff (!rstN)
        strobes.cpuTick |=> !strobes.cpuTick);
    end
  endgenerate

endmodule

// File: rtl/raster_regs.sv
module raster_regs
  import raster_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  rasterStrobeT strobes,
  input  logic         ctrlWrEn,
  input  logic         maskWrEn,
  input  logic [7:0]   wrData,
  input  logic         statusRd,
  output logic [7:0]   statusData,
  output logic         irq,
  output logic         renderActive,
  output logic         pixelValid,
  output logic         cpuClkEn
);

  logic irqEn, bgEn, sprEn, vblFlag;
  logic irqEnNext;
  logic unusedWrBits;

  assign unusedWrBits = ^{wrData[6:5], wrData[2:0]};
  assign irqEnNext    = ctrlWrEn ? wrData[7] : irqEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEn   <= 1'b0;
      bgEn    <= 1'b0;
      sprEn   <= 1'b0;
      vblFlag <= 1'b0;
      irq     <= 1'b0;
    end else begin
      irqEn <= irqEnNext;
      if (maskWrEn) begin
        bgEn  <= wrData[3];
        sprEn <= wrData[4];
      end
      if (strobes.vblankSet)
        vblFlag <= 1'b1;
      else if (strobes.vblankClr || statusRd)
        vblFlag <= 1'b0;
      // Pulse on flag set, or on enable rising while the flag is up
      irq <= (strobes.vblankSet && irqEnNext)
           || (ctrlWrEn && wrData[7] && !irqEn && vblFlag);
    end
  end

  assign statusData   = {vblFlag, 7'b0};
  assign renderActive = strobes.drawLine && (bgEn || sprEn);
  assign pixelValid   = strobes.pixelSlot;
  assign cpuClkEn     = strobes.cpuTick;

  // R3: flag reads set after the set strobe
  p_flag_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.vblankSet |=> statusData[7]);

  // R4: status read clears the flag
  p_read_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !strobes.vblankSet) |=> !statusData[7]);

  // R5: prerender clears the flag
  p_auto_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.vblankClr |=> !statusData[7]);

  // R6: interrupt lasts a single dot
  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  // R6: interrupt only with the enable bit on
  p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> irqEn);

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
#(
  parameter int DOTS   = 341,
  parameter int VIS    = 256,
  parameter int RENDER = 240,
  parameter int IDLE   = 1,
  parameter int VBL    = 20,
  parameter int DIV    = 3,
  localparam int TOTAL  = RENDER + IDLE + VBL + 1,
  localparam int DOT_W  = $clog2(DOTS),
  localparam int LINE_W = $clog2(TOTAL)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic              maskWrEn,
  input  logic [7:0]        wrData,
  input  logic              statusRd,
  output logic [7:0]        statusData,
  output logic              irq,
  output logic              renderActive,
  output logic              pixelValid,
  output logic              cpuClkEn,
  output logic [DOT_W-1:0]  dotCount,
  output logic [LINE_W-1:0] lineCount
);

  rasterStrobeT strobes;

  raster_ctrl #(
    .DOTS(DOTS), .VIS(VIS), .RENDER(RENDER),
    .IDLE(IDLE), .VBL(VBL), .DIV(DIV)
  ) i_ctrl (
    .clk(clk), .rstN(rstN),
    .dotCount(dotCount), .lineCount(lineCount),
    .strobes(strobes)
  );

  raster_regs i_regs (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .ctrlWrEn(ctrlWrEn), .maskWrEn(maskWrEn), .wrData(wrData),
    .statusRd(statusRd), .statusData(statusData), .irq(irq),
    .renderActive(renderActive), .pixelValid(pixelValid),
    .cpuClkEn(cpuClkEn)
  );

endmodule

// File: tb/test_raster_timing_gen.sv
`timescale 1ns/1ps
module test_raster_timing_gen;

  localparam int DOTS   = 12;
  localparam int VIS    = 8;
  localparam int RENDER = 4;
  localparam int IDLE   = 1;
  localparam int VBL    = 3;
  localparam int DIV    = 3;
  localparam int LINES  = RENDER + IDLE + VBL + 1;
  localparam int FRAME  = LINES * DOTS;
  localparam int START  = RENDER * DOTS;

  // Walk table: position, expected pixelValid, renderActive, flag (mask bg on, irq off)
  localparam int N = 11;
  localparam int T_LINE [N] = '{4, 5, 5, 7,  8, 8, 0, 0, 0, 0, 3};
  localparam int T_DOT  [N] = '{5, 1, 2, 11, 1, 2, 0, 1, 8, 9, 11};
  localparam int T_PIX  [N] = '{0, 0, 0, 0,  0, 0, 0, 1, 1, 0, 0};
  localparam int T_REN  [N] = '{0, 0, 0, 0,  1, 1, 1, 1, 1, 1, 1};
  localparam int T_VBL  [N] = '{0, 0, 1, 1,  1, 0, 0, 0, 0, 0, 0};

  logic clk = 0;
  logic rstN = 0;
  logic ctrlWrEn = 0, maskWrEn = 0, statusRd = 0;
  logic [7:0] wrData = '0;
  logic [7:0] statusData;
  logic irq, renderActive, pixelValid, cpuClkEn;
  logic [3:0] dotCount, lineCount;

  int checks = 0;
  int fails = 0;
  int pos = 0;
  int kCount = 0;

  always #2 clk = ~clk;

  raster_timing_gen #(
    .DOTS(DOTS), .VIS(VIS), .RENDER(RENDER),
    .IDLE(IDLE), .VBL(VBL), .DIV(DIV)
  ) i_raster_timing_gen (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .maskWrEn(maskWrEn),
    .wrData(wrData), .statusRd(statusRd), .statusData(statusData),
    .irq(irq), .renderActive(renderActive), .pixelValid(pixelValid),
    .cpuClkEn(cpuClkEn), .dotCount(dotCount), .lineCount(lineCount)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (line %0d dot %0d)",
               req, act, exp, pos / DOTS, pos % DOTS);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    pos = (pos + 1) % FRAME;
    kCount++;
    @(negedge clk);
  endtask

  task automatic stepTo(input int l, input int d);
    while (pos != l * DOTS + d) tick();
  endtask

  task automatic writeCtrl(input logic [7:0] v);
    ctrlWrEn = 1; wrData = v;
    tick();
    ctrlWrEn = 0; wrData = '0;
  endtask

  task automatic writeMask(input logic [7:0] v);
    maskWrEn = 1; wrData = v;
    tick();
    maskWrEn = 0; wrData = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 dot", dotCount, 0);
    check("R11 line", lineCount, RENDER);
    check("R11 flag", statusData, 0);
    check("R11 irq", irq, 0);
    rstN = 1;
    pos = START;
    kCount = 0;

    // R10: processor enable every third dot
    for (int i = 0; i < 30; i++) begin
      check("R10 cpuClkEn", cpuClkEn, (kCount % DIV == DIV - 1) ? 1 : 0);
      tick();
    end

    // Background on, interrupt off; walk the table
    writeMask(8'h08);
    for (int i = 0; i < N; i++) begin
      stepTo(T_LINE[i], T_DOT[i]);
      check("R1 dot", dotCount, T_DOT[i]);
      check("R2 line", lineCount, T_LINE[i]);
      check("R9 pixelValid", pixelValid, T_PIX[i]);
      check("R8 renderActive", renderActive, T_REN[i]);
      check("R3/R5 flag", statusData, T_VBL[i] ? 8'h80 : 8'h00);
      check("R6 irq disabled", irq, 0);
    end

    // R7: enable while flag clear gives no pulse
    writeCtrl(8'h80);
    check("R7 no pulse", irq, 0);
    stepTo(5, 1);
    check("R6 before set", irq, 0);
    stepTo(5, 2);
    check("R6 pulse", irq, 1);
    check("R3 flag", statusData, 8'h80);
    tick();
    check("R6 single dot", irq, 0);
    writeCtrl(8'h00);
    check("R6 off", irq, 0);
    writeCtrl(8'h80);
    check("R7 late enable pulse", irq, 1);
    tick();
    check("R7 single dot", irq, 0);

    // R4: read returns flag, clear after the read
    check("R4 read value", statusData, 8'h80);
    statusRd = 1;
    tick();
    statusRd = 0;
    check("R4 cleared", statusData, 8'h00);
    check("R4 no irq", irq, 0);

    // R8 mask variants on a render line
    stepTo(1, 3);
    writeMask(8'h10);
    check("R8 sprites only", renderActive, 1);
    writeMask(8'h00);
    check("R8 display off", renderActive, 0);
    check("R9 independent of mask", pixelValid, 1);
    writeMask(8'h18);
    check("R8 both on", renderActive, 1);
    writeMask(8'hE7);
    check("R8 other bits ignored", renderActive, 0);
    stepTo(8, 0);
    check("R8 prerender off", renderActive, 0);
    writeMask(8'h08);
    check("R8 prerender on", renderActive, 1);
    check("R2 prerender line", lineCount, 8);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule